// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Address-Width Discovery

This block reads 16-bit words from a three-wire serial EEPROM. The wires are chip select, serial clock, data toward the memory and data from the memory. Each access sends a three-bit read frame, then the word address, and then clocks in sixteen data bits. The serial clock advances only on a bit-period `tick` supplied from outside. Each half of a serial clock period therefore lasts one tick interval.

The address width of the attached memory does not need to be known in advance. When the width is unknown, the reader sends zero address bits, up to eight of them, and samples the memory's data line after each one. The memory drives a dummy zero once it has received its last address bit. The number of bits sent up to that point is the width, and it is kept for later reads. After such a discovery frame, the same word is read again with the width just found. A single-word read (`scan` low) fetches the word at `rd_addr`. A scan (`scan` high) discovers the width again, reads every word from address 0 to the highest address in order, and adds them modulo 2^16. The checksum flag reports whether that sum equals 0xBABA.

Words leave through a valid/ready port. `word_valid` stays high with `word_data` held steady until `word_ready` is seen high on a clock edge. While a word waits for acceptance the serial lines stay idle, so back-pressure simply pauses the device traffic.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, chip select, serial clock, data-in, `word_valid`, `done`, `width_err` and `csum_ok` are low, and `addr_width` is 0.
- R2: Every frame starts with chip select rising, followed by the bits 1, 1, 0 in that order. Each bit is driven while the serial clock is low and is held steady while the clock is high. The clock changes level only on a tick.
- R3: When the width is known, the address goes out MSB first using exactly `addr_width` bits.
- R4: When the width is unknown, zero address bits are sent and data-out is sampled at the end of each clock-high phase. The first 0 sampled ends the frame, and `addr_width` becomes the number of address bits sent.
- R5: If no 0 is seen within 8 address bits, `width_err` is set and `addr_width` becomes 8. A later successful discovery clears `width_err`.
- R6: A discovery frame delivers no word. The requested word is then read again in a second frame using the discovered width, and only that word is delivered.
- R7: The 16 data bits are sampled at the end of each clock-high phase, and the first bit sampled is the MSB of `word_data`.
- R8: Chip select, serial clock and data-in are low for at least one tick between frames, and they stay low while a word is offered.
- R9: Once offered, a word keeps `word_valid` high and `word_data` unchanged until it is accepted. No serial clock edge occurs while the word waits.
- R10: A scan rediscovers the width and then delivers the words from address 0 to 2^`addr_width`-1 in increasing order, after which `done` goes high.
- R11: At the end of a scan, `csum_ok` is high exactly when the sum of all delivered words modulo 2^16 equals 0xBABA. A new start clears it, and a single-word read leaves it low.
- R12: A single-word read uses the stored width in one frame when the width is known. When no width is known, it first runs a discovery frame.
- R13: A start pulse arriving while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Bit-period strobe, one cycle wide |
| start | input | 1 | Begin an operation (used only when idle) |
| scan | input | 1 | 1: full-device scan, 0: single word |
| rd_addr | input | 8 | Word address for a single read |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| word_data | output | 16 | Word read |
| word_valid | output | 1 | Word is offered |
| word_ready | input | 1 | Consumer accepts the word |
| addr_width | output | 4 | Discovered address width |
| width_err | output | 1 | No dummy zero seen within 8 address bits |
| done | output | 1 | Operation complete (held until next start) |
| csum_ok | output | 1 | Scan checksum equals 0xBABA |

## Verification
A behavioural memory model is attached for address widths 6, 7 and 8. Each of these widths stops discovery at a different bit count and selects a different scan length. A width of 9, which never returns the dummy zero in time, exercises the error path. Single reads are issued both before and after a width is known, and the bench counts chip-select frames to tell a reread after discovery from a direct read. Scans run with one checksum-correct image and one image off by one, and the consumer inserts stall patterns of varying length. A start pulse is injected in the middle of a scan.

// File: rtl/eer_pkg.sv
package eer_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DATA, S_GAP, S_EMIT
  } eer_state_t;

  // start bit followed by the read opcode, MSB sent first
  localparam logic [2:0] READ_FRAME = 3'b110;
endpackage

// File: rtl/eer_phase.sv
module eer_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic ph,
  output logic bit_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph <= 1'b0;
    else if (!run)   ph <= 1'b0;
    else if (tick)   ph <= ~ph;
  end

  assign bit_done = run & tick & ph;

  p_phase_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ph) |-> $past(tick));
endmodule

// File: rtl/eer_csum.sv
module eer_csum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] din,
  output logic [W-1:0] sum,
  output logic [W-1:0] nxt
);
  assign nxt = sum + din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum <= '0;
    else if (clr)  sum <= '0;
    else if (add)  sum <= nxt;
  end
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader #(
  parameter int          MAX_AW    = 8,
  parameter int          WORD_W    = 16,
  parameter logic [15:0] CSUM_GOOD = 16'hBABA
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          start,
  input  logic                          scan,
  input  logic [MAX_AW-1:0]             rd_addr,
  output logic                          ee_cs,
  output logic                          ee_sk,
  output logic                          ee_di,
  input  logic                          ee_do,
  output logic [WORD_W-1:0]             word_data,
  output logic                          word_valid,
  input  logic                          word_ready,
  output logic [$clog2(MAX_AW+1)-1:0]   addr_width,
  output logic                          width_err,
  output logic                          done,
  output logic                          csum_ok
);
  import eer_pkg::*;

  localparam int AW_W  = $clog2(MAX_AW + 1);
  localparam int CNT_W = $clog2((WORD_W > MAX_AW) ? WORD_W : MAX_AW);
  localparam logic [CNT_W-1:0]  C_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0]  C_CMD  = CNT_W'(2);
  localparam logic [CNT_W-1:0]  C_DATA = CNT_W'(WORD_W - 1);
  localparam logic [AW_W-1:0]   AW_MAX = AW_W'(MAX_AW);

  eer_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [AW_W-1:0]   aw;
  logic              aw_known, discover, redo, scan_q;
  logic [MAX_AW-1:0] cur;
  logic [WORD_W-1:0] shreg;
  logic              done_q, err_q, csum_ok_q;
  logic              run, ph, bit_done;
  logic [WORD_W-1:0] sum, sum_nxt;
  logic [AW_W-1:0]   aw_use;
  logic [MAX_AW:0]   span;
  logic [MAX_AW-1:0] cur_sh;
  logic              last_hit;

  assign run    = (st == S_CMD) || (st == S_ADDR) || (st == S_DATA);
  assign aw_use = discover ? AW_MAX : aw;
  assign span   = ((MAX_AW+1)'(1) << aw) - (MAX_AW+1)'(1);
  assign last_hit = ({1'b0, cur} == span);
  assign cur_sh = cur >> cnt;

  eer_phase u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .ph(ph), .bit_done(bit_done)
  );

  eer_csum #(.W(WORD_W)) u_csum (
    .clk(clk), .rst_n(rst_n),
    .clr(st == S_IDLE && start && scan),
    .add(st == S_EMIT && word_ready),
    .din(shreg), .sum(sum), .nxt(sum_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; aw <= '0; aw_known <= 1'b0;
      discover <= 1'b0; redo <= 1'b0; scan_q <= 1'b0; cur <= '0;
      shreg <= '0; done_q <= 1'b0; err_q <= 1'b0; csum_ok_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          scan_q    <= scan;
          cur       <= scan ? '0 : rd_addr;
          discover  <= scan | ~aw_known;
          if (scan) aw_known <= 1'b0;
          if (scan | ~aw_known) err_q <= 1'b0;
          done_q    <= 1'b0;
          csum_ok_q <= 1'b0;
          redo      <= 1'b0;
          cnt       <= C_CMD;
          st        <= S_CMD;
        end
        S_CMD: if (bit_done) begin
          if (cnt == '0) begin
            cnt <= CNT_W'(aw_use - AW_W'(1));
            st  <= S_ADDR;
          end else cnt <= cnt - C_ONE;
        end
        S_ADDR: if (bit_done) begin
          if (discover) begin
            if (!ee_do || cnt == '0) begin
              aw       <= ee_do ? AW_MAX : AW_MAX - AW_W'(cnt);
              err_q    <= ee_do;
              aw_known <= 1'b1;
              redo     <= 1'b1;
              st       <= S_GAP;
            end else cnt <= cnt - C_ONE;
          end else if (cnt == '0) begin
            cnt <= C_DATA;
            st  <= S_DATA;
          end else cnt <= cnt - C_ONE;
        end
        S_DATA: if (bit_done) begin
          shreg <= {shreg[WORD_W-2:0], ee_do};
          if (cnt == '0) st <= S_GAP;
          else cnt <= cnt - C_ONE;
        end
        S_GAP: if (tick) begin
          if (redo) begin
            redo     <= 1'b0;
            discover <= 1'b0;
            cnt      <= C_CMD;
            st       <= S_CMD;
          end else st <= S_EMIT;
        end
        S_EMIT: if (word_ready) begin
          if (scan_q && !last_hit) begin
            cur <= cur + MAX_AW'(1);
            cnt <= C_CMD;
            st  <= S_CMD;
          end else begin
            done_q <= 1'b1;
            if (scan_q) csum_ok_q <= (sum_nxt == CSUM_GOOD);
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_CMD:   ee_di = READ_FRAME[cnt[1:0]];
      S_ADDR:  ee_di = discover ? 1'b0 : cur_sh[0];
      default: ee_di = 1'b0;
    endcase
  end

  assign ee_cs      = run;
  assign ee_sk      = ph;
  assign word_data  = shreg;
  assign word_valid = (st == S_EMIT);
  assign addr_width = aw;
  assign width_err  = err_q;
  assign done       = done_q;
  assign csum_ok    = csum_ok_q;

  p_sk_inside_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  p_di_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ee_sk) && ee_sk) |-> $stable(ee_di));
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));
  p_cs_low_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !ee_cs);
  p_width_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_width <= AW_MAX);
  p_err_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    width_err |-> (addr_width == AW_MAX));
  p_done_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ee_cs);
endmodule

// File: tb/eeprom_word_reader_test.sv
module eeprom_word_reader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start = 1'b0, scan = 1'b0, word_ready = 1'b0;
  logic [7:0] rd_addr = '0;
  logic ee_cs, ee_sk, ee_di;
  logic ee_do = 1'b1;
  logic [15:0] word_data;
  logic word_valid, width_err, done, csum_ok;
  logic [3:0] addr_width;

  int total = 0, bad = 0;
  int model_aw = 6;
  logic [15:0] mem [0:255];
  int m_edge = 0, m_idx = 0, m_last_addr = 0;
  int sessions = 0, frame_bad = 0, sk_rises = 0, di_bad = 0;
  logic [31:0] rx = '0;
  logic [2:0] m_hdr = '0;
  logic prev_sk = 1'b0, prev_di = 1'b0;
  int tdiv = 0;

  eeprom_word_reader uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .scan(scan),
    .rd_addr(rd_addr), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .addr_width(addr_width), .width_err(width_err),
    .done(done), .csum_ok(csum_ok)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 2;
    tick <= (tdiv == 0);
  end

  // serial memory model: dummy zero after the last address bit, then data MSB first
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      if (m_edge > 0) begin
        sessions++;
        if (m_edge < 3 || m_hdr != 3'b110) frame_bad++;
      end
      m_edge = 0; rx = '0; ee_do = 1'b1;
    end else begin
      m_edge++; sk_rises++;
      rx = {rx[30:0], ee_di};
      if (m_edge == 3) m_hdr = rx[2:0];
      if (m_edge == 3 + model_aw) begin
        m_last_addr = int'(rx & ((32'd1 << model_aw) - 1));
        m_idx = m_last_addr & 255;
        ee_do = 1'b0;
      end else if (m_edge > 3 + model_aw) begin
        automatic int k = m_edge - 3 - model_aw;
        ee_do = (k <= 16) ? mem[m_idx][16-k] : 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && ee_sk && prev_sk && ee_di != prev_di) di_bad++;
    prev_sk <= ee_sk;
    prev_di <= ee_di;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input int aw, input bit good);
    automatic int n = (aw > 8) ? 256 : (1 << aw);
    automatic logic [15:0] s = '0;
    model_aw = aw;
    for (int i = 0; i < n - 1; i++) begin
      mem[i] = 16'(i * 16'h2B1D + 16'h0417 + aw);
      s = s + mem[i];
    end
    mem[n-1] = 16'hBABA - s + (good ? 16'h0 : 16'h1);
  endtask

  task automatic go(input bit sc, input int a);
    @(negedge clk);
    start = 1'b1; scan = sc; rd_addr = 8'(a);
  endtask

  task automatic collect(input bit chk_data, input int base, input bit inject, output int got);
    int stall;
    logic [15:0] held;
    int rises_h;
    got = 0; stall = 0; held = '0; rises_h = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      word_ready = 1'b0; start = 1'b0;
      if (word_valid) begin
        if (stall == 0) begin
          held = word_data; rises_h = sk_rises;
          chk(!ee_cs, "R8 cs during offer", 32'(ee_cs), 0);
        end else begin
          chk(word_data == held, "R9 data held", 32'(word_data), 32'(held));
          chk(sk_rises == rises_h, "R9 no clock while waiting", sk_rises, rises_h);
        end
        if (inject && got == 10 && stall == 0) begin
          start = 1'b1; scan = 1'b0; rd_addr = 8'd3; // R13
        end
        if (stall >= got % 3) begin
          if (chk_data)
            chk(word_data == mem[base + got], "R7 R10 word", 32'(word_data), 32'(mem[base + got]));
          word_ready = 1'b1; got++; stall = 0;
        end else stall++;
      end
      @(negedge clk);
    end
    word_ready = 1'b0; start = 1'b0;
  endtask

  task automatic run_scan(input int aw, input bit good, input bit inject);
    int got, s0;
    fill(aw, good);
    s0 = sessions;
    go(1'b1, 0);
    collect(1'b1, 0, inject, got);
    chk(got == (1 << aw), "R10 word count", got, 1 << aw);
    chk(sessions - s0 == (1 << aw) + 1, "R6 frames incl discovery", sessions - s0, (1 << aw) + 1);
    chk(addr_width == 4'(aw), "R4 width", 32'(addr_width), aw);
    chk(!width_err, "R5 no error", 32'(width_err), 0);
    chk(csum_ok == good, "R11 checksum flag", 32'(csum_ok), 32'(good));
    if (inject) chk(got == (1 << aw), "R13 scan not disturbed", got, 1 << aw);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int got, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!ee_cs && !ee_sk && !ee_di, "R1 serial lines", {ee_cs, ee_sk, ee_di}, 0);
    chk(!word_valid && !done, "R1 valid/done", {word_valid, done}, 0);
    chk(addr_width == 0 && !width_err && !csum_ok, "R1 width/flags",
        {addr_width, width_err, csum_ok}, 0);

    // R12 single read with no known width: discovery then reread
    fill(6, 1'b1);
    s0 = sessions;
    go(1'b0, 5);
    collect(1'b1, 5, 1'b0, got);
    chk(got == 1, "R6 one word delivered", got, 1);
    chk(sessions - s0 == 2, "R12 discovery plus reread", sessions - s0, 2);
    chk(addr_width == 6, "R4 width found", 32'(addr_width), 6);
    chk(m_last_addr == 5, "R3 address sent", m_last_addr, 5);
    chk(!csum_ok, "R11 single read flag", 32'(csum_ok), 0);

    // R12 known width: one frame, top address
    s0 = sessions;
    go(1'b0, 63);
    collect(1'b1, 63, 1'b0, got);
    chk(sessions - s0 == 1, "R12 single frame", sessions - s0, 1);
    chk(m_last_addr == 63, "R3 address sent", m_last_addr, 63);

    run_scan(6, 1'b1, 1'b1);
    run_scan(7, 1'b1, 1'b0);
    run_scan(8, 1'b1, 1'b0);
    run_scan(7, 1'b0, 1'b0);

    // R5 no dummy zero within 8 bits
    fill(9, 1'b1);
    go(1'b1, 0);
    collect(1'b0, 0, 1'b0, got);
    chk(width_err, "R5 error flag", 32'(width_err), 1);
    chk(addr_width == 8, "R5 width forced", 32'(addr_width), 8);
    chk(got == 256, "R5 R10 scan length", got, 256);

    run_scan(6, 1'b1, 1'b0);

    chk(frame_bad == 0, "R2 frame header", frame_bad, 0);
    chk(di_bad == 0, "R2 data steady while clock high", di_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule